// File: doc/BRIEF.md
# Dual Channel Reloadable Down Timer

A small peripheral with two independent down-counting timer channels that tick once per system clock, with no prescaler. Software writes a start value into a channel's set-count register and sets the channel's run bit. From then on the channel counts down once per clock. Software can read the running value at any time from a separate read-only current-count address. Reading that address never disturbs the stored start value.

When a running channel reaches zero, it raises its event bit in a shared status register. With reload enabled, the channel then reloads its start value and keeps going. Otherwise it stops and holds at zero. A single interrupt line is the OR of the pending events whose per-channel enable is set. Reading the status register clears the pending events. While a channel's event is pending, that channel's start value is locked against writes.

The bus is a plain synchronous register port. It has an address, a write strobe with data, and a read strobe. Read data appears one clock after the read strobe.

Top module: `dual_down_timer`

## Requirements
- R1: After a synchronous active-high reset, all registers read zero, `irq` is low and `rd_data` is zero.
- R2: The mode register is at byte offset 0x00, with these fields:
  - run for channel 0 and channel 1 in bits 0 and 1;
  - reload enable for channel 0 and channel 1 in bits 4 and 5;
  - interrupt enable for channel 0 and channel 1 in bits 8 and 9.

  Writing a run bit from 0 to 1 loads that channel's counter from its set-count register. Writing a run bit that is already 1 does not reload the counter. When a mode write falls in the same cycle as a hardware run clear, the write wins.
- R3: The set-count registers are at 0x04 (channel 0) and 0x08 (channel 1). They are read-write and use the low 16 bits. The current-count registers are at 0x0C and 0x10 and are read-only. The status register is at 0x14. Read data is registered: it appears in the cycle after `rd_en` and holds until the next read. A read of any other address, including a misaligned one, returns 0. A write to a read-only or unmapped address changes nothing.
- R4: While a channel runs with a nonzero count, its counter decreases by exactly one per clock. Reading the current count does not change the count or the set value.
- R5: A running channel whose count is zero sets its status event bit on the next clock: bit 0 for channel 0, bit 1 for channel 1.
- R6: At zero with reload enabled, the counter loads the set value on the next clock and stays running. With reload disabled, the run bit clears and the count stays at zero.
- R7: A write to a channel's set-count register is ignored while that channel's event bit is set.
- R8: `irq` is high exactly when some channel has both its event bit and its interrupt enable bit set.
- R9: A read of the status register returns the event bits and clears them on the same clock. An event that occurs on that same clock stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Masked interrupt, OR of enabled pending events |

## Verification
The assertions assume at most one bus access per cycle. A cycle with both `wr_en` and `rd_en` treats them as two operations on one address, and the checks allow for this. The bench never drives both strobes in the same cycle. Its random phase issues one write, one read or an idle stretch per operation. Random set values are kept small, so terminal counts, reloads, locked writes and reads that collide with an event all occur often.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int NUM_CH = 2;

    localparam logic [31:0] OFS_MODE = 32'h00;
    localparam logic [31:0] OFS_SET0 = 32'h04;
    localparam logic [31:0] OFS_SET1 = 32'h08;
    localparam logic [31:0] OFS_CUR0 = 32'h0C;
    localparam logic [31:0] OFS_CUR1 = 32'h10;
    localparam logic [31:0] OFS_STAT = 32'h14;

    typedef enum logic [2:0] {
        SEL_MODE,
        SEL_SET0,
        SEL_SET1,
        SEL_CUR0,
        SEL_CUR1,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] rel;
        logic [NUM_CH-1:0] run;
    } mode_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        case (a)
            OFS_MODE: decode_addr = SEL_MODE;
            OFS_SET0: decode_addr = SEL_SET0;
            OFS_SET1: decode_addr = SEL_SET1;
            OFS_CUR0: decode_addr = SEL_CUR0;
            OFS_CUR1: decode_addr = SEL_CUR1;
            OFS_STAT: decode_addr = SEL_STAT;
            default:  decode_addr = SEL_NONE;
        endcase
    endfunction

    // Mode word layout: run [1:0], reload [5:4], int enable [9:8]
    function automatic logic [31:0] mode_to_word(input mode_t m);
        mode_to_word = 32'({m.ie, 2'b00, m.rel, 2'b00, m.run});
    endfunction

    function automatic mode_t word_to_mode(input logic [31:0] w);
        mode_t m;
        m.run = w[1:0];
        m.rel = w[5:4];
        m.ie  = w[9:8];
        word_to_mode = m;
    endfunction

endpackage

// File: rtl/dtmr_mode_reg.sv
module dtmr_mode_reg
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  mode_t             wr_mode,
    input  logic [NUM_CH-1:0] run_clr,
    output mode_t             mode_q,
    output logic [NUM_CH-1:0] start
);

    // A start is a run bit written from 0 to 1
    assign start = wr ? (wr_mode.run & ~mode_q.run) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr) begin
            mode_q <= wr_mode;
        end else begin
            mode_q.run <= mode_q.run & ~run_clr;
        end
    end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             rel,
    input  logic             set_wr,
    input  logic [CNT_W-1:0] set_data,
    input  logic             evt_pend,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] set_q,
    output logic             tc,
    output logic             run_clr
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);
    assign tc      = run & at_zero;
    assign run_clr = tc & ~rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
        end else if (set_wr && !evt_pend) begin
            set_q <= set_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= set_q;
        end else if (run) begin
            if (at_zero) begin
                cnt_q <= rel ? set_q : '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dtmr_status.sv
module dtmr_status
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tc,
    input  logic              clr,
    input  logic [NUM_CH-1:0] ie,
    output logic [NUM_CH-1:0] evt_q,
    output logic              irq
);

    logic [NUM_CH-1:0] kept;

    assign kept = clr ? '0 : evt_q;
    assign irq  = |(evt_q & ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q <= kept | tc;
        end
    end

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    reg_sel_e                      sel;
    mode_t                         mode_q;
    logic [NUM_CH-1:0]             start;
    logic [NUM_CH-1:0]             tc;
    logic [NUM_CH-1:0]             run_clr;
    logic [NUM_CH-1:0]             evt_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  set_q;
    logic [31:0]                   wr_word;
    logic                          mode_wr;
    logic                          stat_rd;
    logic [DATA_W-1:0]             rd_next;
    logic                          unused_wr_bits;

    assign sel     = decode_addr(32'(addr));
    assign wr_word = 32'(wr_data);
    assign mode_wr = wr_en && (sel == SEL_MODE);
    assign stat_rd = rd_en && (sel == SEL_STAT);
    assign unused_wr_bits = ^wr_word;

    dtmr_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr      (mode_wr),
        .wr_mode (word_to_mode(wr_word)),
        .run_clr (run_clr),
        .mode_q  (mode_q),
        .start   (start)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam reg_sel_e SET_SEL = (ch == 0) ? SEL_SET0 : SEL_SET1;
        dtmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .start    (start[ch]),
            .run      (mode_q.run[ch]),
            .rel      (mode_q.rel[ch]),
            .set_wr   (wr_en && (sel == SET_SEL)),
            .set_data (wr_data[CNT_W-1:0]),
            .evt_pend (evt_q[ch]),
            .cnt_q    (cnt_q[ch]),
            .set_q    (set_q[ch]),
            .tc       (tc[ch]),
            .run_clr  (run_clr[ch])
        );
    end

    dtmr_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .tc    (tc),
        .clr   (stat_rd),
        .ie    (mode_q.ie),
        .evt_q (evt_q),
        .irq   (irq)
    );

    always_comb begin
        case (sel)
            SEL_MODE: rd_next = DATA_W'(mode_to_word(mode_q));
            SEL_SET0: rd_next = DATA_W'(set_q[0]);
            SEL_SET1: rd_next = DATA_W'(set_q[1]);
            SEL_CUR0: rd_next = DATA_W'(cnt_q[0]);
            SEL_CUR1: rd_next = DATA_W'(cnt_q[1]);
            SEL_STAT: rd_next = DATA_W'(evt_q);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            addr,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic                         irq,
    input mode_t                        mode_q,
    input logic [NUM_CH-1:0]            evt_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] set_q
);

    logic mode_wr_c;
    logic stat_rd_c;

    assign mode_wr_c = wr_en && (decode_addr(32'(addr)) == SEL_MODE);
    assign stat_rd_c = rd_en && (decode_addr(32'(addr)) == SEL_STAT);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R4
        a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
            (mode_q.run[ch] && cnt_q[ch] != '0) |=> (cnt_q[ch] == $past(cnt_q[ch]) - 1'b1));
        // R5
        a_r5_event_set: assert property (@(posedge clk) disable iff (rst)
            (mode_q.run[ch] && cnt_q[ch] == '0) |=> evt_q[ch]);
        // R6
        a_r6_reload: assert property (@(posedge clk) disable iff (rst)
            (mode_q.run[ch] && cnt_q[ch] == '0 && mode_q.rel[ch]) |=> (cnt_q[ch] == $past(set_q[ch])));
        // R6
        a_r6_stop: assert property (@(posedge clk) disable iff (rst)
            (mode_q.run[ch] && cnt_q[ch] == '0 && !mode_q.rel[ch] && !mode_wr_c)
            |=> (!mode_q.run[ch] && cnt_q[ch] == '0));
        // R7
        a_r7_set_locked: assert property (@(posedge clk) disable iff (rst)
            evt_q[ch] |=> $stable(set_q[ch]));
        // R9
        a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
            (stat_rd_c && !(mode_q.run[ch] && cnt_q[ch] == '0)) |=> !evt_q[ch]);
    end

    // R8
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((evt_q & mode_q.ie) != '0));

endmodule

bind dual_down_timer dtmr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .irq    (irq),
    .mode_q (mode_q),
    .evt_q  (evt_q),
    .cnt_q  (cnt_q),
    .set_q  (set_q)
);

// File: tb/sim_dual_down_timer.sv
module sim_dual_down_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state built from the requirements
    logic [1:0]  m_run, m_rel, m_ie, m_evt;
    logic [15:0] m_set [2];
    logic [15:0] m_cnt [2];
    logic [31:0] m_rd;

    dual_down_timer u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return {22'd0, m_ie, 2'b00, m_rel, 2'b00, m_run};
            8'h04:   return {16'd0, m_set[0]};
            8'h08:   return {16'd0, m_set[1]};
            8'h0C:   return {16'd0, m_cnt[0]};
            8'h10:   return {16'd0, m_cnt[1]};
            8'h14:   return {30'd0, m_evt};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic model_irq();
        return |(m_evt & m_ie);
    endfunction

    always @(posedge clk) begin
        logic [1:0]  tcv, run_n, evt_n;
        logic [15:0] cnt_n [2];
        logic [15:0] set_n [2];
        if (rst) begin
            m_run = '0; m_rel = '0; m_ie = '0; m_evt = '0; m_rd = '0;
            for (int i = 0; i < 2; i++) begin
                m_set[i] = '0; m_cnt[i] = '0;
            end
        end else begin
            for (int i = 0; i < 2; i++) tcv[i] = m_run[i] && (m_cnt[i] == 16'd0);
            if (rd_en) m_rd = model_read(addr);
            for (int i = 0; i < 2; i++) begin
                set_n[i] = m_set[i];
                if (wr_en && addr == 8'(4 + 4 * i) && !m_evt[i]) set_n[i] = wr_data[15:0];
                if (wr_en && addr == 8'h00 && wr_data[i] && !m_run[i]) cnt_n[i] = m_set[i];
                else if (m_run[i]) cnt_n[i] = (m_cnt[i] == 16'd0) ? (m_rel[i] ? m_set[i] : 16'd0)
                                                                  : m_cnt[i] - 16'd1;
                else cnt_n[i] = m_cnt[i];
            end
            evt_n = ((rd_en && addr == 8'h14) ? 2'b00 : m_evt) | tcv;
            run_n = m_run & ~(tcv & ~m_rel);
            if (wr_en && addr == 8'h00) begin
                run_n = wr_data[1:0];
                m_rel = wr_data[5:4];
                m_ie  = wr_data[9:8];
            end
            m_run = run_n;
            m_evt = evt_n;
            for (int i = 0; i < 2; i++) begin
                m_set[i] = set_n[i]; m_cnt[i] = cnt_n[i];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, m_rd);
        check({tag, " irq"}, {31'd0, irq}, {31'd0, model_irq()});
    endtask

    task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd(a, tag);
        check({tag, " fixed"}, rd_data, exp);
    endtask

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04, 8'h08: return "R7";
            8'h0C, 8'h10: return "R4";
            8'h14: return "R9";
            default: return "R3";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        check("R1 rd_data", rd_data, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        rdx(8'h00, 0, "R1"); rdx(8'h04, 0, "R1"); rdx(8'h08, 0, "R1");
        rdx(8'h0C, 0, "R1"); rdx(8'h10, 0, "R1"); rdx(8'h14, 0, "R1");

        // R2 / R4: load on run rising, count down, reads do not disturb
        wr(8'h04, 32'd10);
        wr(8'h00, 32'h1);
        idle(3);
        rd(8'h0C, "R4");
        rd(8'h0C, "R4");
        rdx(8'h04, 32'd10, "R4");

        // R5 / R6: terminal without reload
        idle(15);
        rdx(8'h00, 32'h0, "R6");
        rdx(8'h0C, 32'h0, "R6");
        // R7: set write locked while event pending
        wr(8'h04, 32'd77);
        rdx(8'h04, 32'd10, "R7");
        rdx(8'h14, 32'h1, "R5");
        rdx(8'h14, 32'h0, "R9");
        wr(8'h04, 32'd3);
        rdx(8'h04, 32'd3, "R7");

        // R8: masked interrupt
        wr(8'h00, 32'h101);
        idle(6);
        check("R8 irq on", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'h0);
        check("R8 irq masked", {31'd0, irq}, 32'd0);
        rdx(8'h14, 32'h1, "R8");

        // R9: event each cycle survives a status read
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h22);
        idle(2);
        rdx(8'h14, 32'h2, "R9");
        rdx(8'h14, 32'h2, "R9");
        rdx(8'h10, 32'h0, "R6");
        rdx(8'h00, 32'h22, "R6");
        wr(8'h00, 32'h0);
        idle(1);
        rd(8'h14, "R9");
        rdx(8'h14, 32'h0, "R9");

        // R6: reload keeps running
        wr(8'h08, 32'd4);
        wr(8'h00, 32'h22);
        idle(7);
        rd(8'h10, "R6");
        rdx(8'h00, 32'h22, "R6");
        // R2: writing run again does not reload
        wr(8'h00, 32'h22);
        rd(8'h10, "R2");

        // R3: unmapped, misaligned, read-only
        rdx(8'h18, 32'h0, "R3");
        rdx(8'h02, 32'h0, "R3");
        wr(8'h0C, 32'h55);
        rd(8'h0C, "R3");

        // Random phase
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [7:0] a;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                idle($urandom_range(1, 12));
            end else if (op < 7) begin
                a = 8'(4 * $urandom_range(0, 6));
                rd(a, tag_of(a));
            end else if (op < 8) begin
                wr(8'h00, {22'd0, 2'($urandom), 2'b00, 2'($urandom), 2'b00, 2'($urandom)});
            end else begin
                wr(8'(4 * $urandom_range(1, 2)), 32'($urandom_range(0, 30)));
            end
            check("R8 irq random", {31'd0, irq}, {31'd0, model_irq()});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule